// File: doc/BRIEF.md
# Multidrop 9-Bit Receive Address Filter

This block sits between a UART receive deserializer and the receive FIFO on an RS-485 multidrop link. Every received character arrives with a ninth bit: 1 marks a station address, 0 marks a data byte. The filter decides, in the cycle the character arrives, whether it is pushed into the FIFO and which value the flag bit that goes with it carries. It also raises a line-status interrupt whenever an address character is accepted.

Two multidrop modes exist. In host-managed mode the host reads each address byte, which always reaches the FIFO, and decides itself whether to turn reception on or off. In automatic mode the block compares address bytes with a programmed station address. It turns reception on when an address matches and off when a different address arrives. Only matching addresses reach the FIFO, with the ninth bit carried in the flag slot. When both mode bits are clear, every character passes straight through with the deserializer's own parity verdict.

Top module: `mdrop_rx_filter`

## Requirements
- R1: After reset the receiver enable (`rx_active`) is 0, `irq` is 0, both mode bits are 0 and the station address is 0x00.
- R2: With the multidrop bit clear (control bit 0 = 0), every valid character is pushed with `push_flag` equal to `char_perr`, whatever the ninth bit, and `irq` is never raised.
- R3: In host-managed mode (control bit 0 = 1, bit 1 = 0), while the receiver is disabled, data characters (ninth bit 0) are not pushed, and address characters (ninth bit 1) are pushed with `push_flag` = 1.
- R4: In host-managed mode, while the receiver is enabled, data characters are pushed with `push_flag` = 0 and address characters with `push_flag` = 1. The receiver enable changes only through host writes.
- R5: When an address character is pushed in either multidrop mode and interrupt enable (control bit 2) is 1, `irq` rises on the next clock and stays high until an `irq_ack` pulse. With control bit 2 = 0 it is not raised. A new raise in the same cycle as an acknowledge wins.
- R6: In automatic mode (control bits 0 and 1 both 1), an address character equal to the station address is pushed with `push_flag` = 1 and turns the receiver enable on from the next clock.
- R7: In automatic mode, while the receiver is disabled, data characters and non-matching address characters are not pushed.
- R8: In automatic mode, a non-matching address character received while the receiver is enabled is not pushed and turns the receiver enable off from the next clock.
- R9: In automatic mode, while the receiver is enabled, data characters are pushed with `push_flag` = 0 until the host clears the enable or a non-matching address arrives.
- R10: `push_valid` is a single-cycle strobe that can be high only in a cycle where `char_valid` is high, with `push_data` equal to `char_data` in that cycle.
- R11: A host control write in the same cycle as a character does not change how that character is handled. For the enable state after that cycle, the host write takes precedence over any automatic change.
- R12: A `ctrl_wr` pulse loads control bit 0 (multidrop), bit 1 (automatic), bit 2 (interrupt enable) and bit 3 (receiver enable) from `ctrl_wdata`. A `stn_wr` pulse loads the station address from `stn_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | Received character present this cycle |
| char_data | input | 8 | Received character, low eight bits |
| char_bit9 | input | 1 | Ninth bit: 1 = address, 0 = data |
| char_perr | input | 1 | Parity verdict of the deserializer, used when multidrop is off |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control value: bit0 multidrop, bit1 automatic, bit2 irq enable, bit3 receiver enable |
| stn_wr | input | 1 | Station address write strobe |
| stn_wdata | input | 8 | Station address value |
| irq_ack | input | 1 | Host acknowledge of the line-status interrupt |
| push_valid | output | 1 | FIFO push strobe |
| push_data | output | 8 | Byte to push |
| push_flag | output | 1 | Flag bit stored with the byte (parity-error slot) |
| irq | output | 1 | Line-status interrupt, level |
| rx_active | output | 1 | Current receiver enable |

## Verification
The hardest case is a host control write landing in the same clock as a received character whose handling would itself change the enable. This is an automatic-mode mismatch while enabled, or a data byte that arrives just as the host enables reception. The directed tasks put both the write strobe and the character on the same negative edge. They check the push outcome in that cycle from the old enable. After the edge they check that the enable holds the written value rather than the automatic one.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

  typedef enum logic [1:0] {
    MD_OFF  = 2'd0,
    MD_SOFT = 2'd1,
    MD_AUTO = 2'd2
  } md_mode_e;

  localparam int unsigned CTRL_W   = 4;
  localparam int unsigned CB_MDROP = 0;
  localparam int unsigned CB_AUTO  = 1;
  localparam int unsigned CB_IRQEN = 2;
  localparam int unsigned CB_RXEN  = 3;

  typedef struct packed {
    logic push;
    logic flag;
    logic addr_evt;
    logic en_set;
    logic en_clr;
  } md_verdict_t;

  // Automatic mode requires the multidrop bit as well.
  function automatic md_mode_e mode_of(input logic mdrop, input logic auto_sel);
    if (!mdrop)   return MD_OFF;
    if (auto_sel) return MD_AUTO;
    return MD_SOFT;
  endfunction

endpackage

// File: rtl/mdrop_ctrl_regs.sv
module mdrop_ctrl_regs
  import mdrop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_wr,
  input  logic [CTRL_W-1:0]    ctrl_wdata,
  input  logic                 stn_wr,
  input  logic [DATA_W-1:0]    stn_wdata,
  input  logic                 auto_set,
  input  logic                 auto_clr,
  output md_mode_e             mode,
  output logic                 irq_en,
  output logic                 rx_en,
  output logic [DATA_W-1:0]    station
);

  logic mdrop_q, auto_q, irq_en_q, rx_en_q;
  logic [DATA_W-1:0] station_q;
  logic rx_en_d;

  // The host write decides the next enable; automatic changes apply otherwise.
  always_comb begin
    rx_en_d = rx_en_q;
    if (ctrl_wr)       rx_en_d = ctrl_wdata[CB_RXEN];
    else if (auto_set) rx_en_d = 1'b1;
    else if (auto_clr) rx_en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdrop_q   <= 1'b0;
      auto_q    <= 1'b0;
      irq_en_q  <= 1'b0;
      rx_en_q   <= 1'b0;
      station_q <= '0;
    end else begin
      rx_en_q <= rx_en_d;
      if (ctrl_wr) begin
        mdrop_q  <= ctrl_wdata[CB_MDROP];
        auto_q   <= ctrl_wdata[CB_AUTO];
        irq_en_q <= ctrl_wdata[CB_IRQEN];
      end
      if (stn_wr) station_q <= stn_wdata;
    end
  end

  assign mode    = mode_of(mdrop_q, auto_q);
  assign irq_en  = irq_en_q;
  assign rx_en   = rx_en_q;
  assign station = station_q;

  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (rx_en == $past(ctrl_wdata[CB_RXEN]))); // R11

  AST_SOFT_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SOFT && !ctrl_wr) |=> $stable(rx_en)); // R4

endmodule

// File: rtl/mdrop_decide.sv
module mdrop_decide
  import mdrop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  md_mode_e             mode,
  input  logic                 rx_en,
  input  logic [DATA_W-1:0]    station,
  input  logic                 char_valid,
  input  logic [DATA_W-1:0]    char_data,
  input  logic                 char_bit9,
  input  logic                 char_perr,
  output logic                 push_valid,
  output logic [DATA_W-1:0]    push_data,
  output logic                 push_flag,
  output logic                 addr_evt,
  output logic                 en_set,
  output logic                 en_clr
);

  function automatic logic addr_hit(input logic [DATA_W-1:0] rx_byte,
                                    input logic [DATA_W-1:0] stn);
    return rx_byte == stn;
  endfunction

  function automatic md_verdict_t judge(input md_mode_e m, input logic en,
                                        input logic is_addr, input logic hit,
                                        input logic perr);
    md_verdict_t v;
    v = '0;
    unique case (m)
      MD_SOFT: begin
        v.push     = is_addr | en;
        v.flag     = is_addr;
        v.addr_evt = is_addr;
      end
      MD_AUTO: begin
        if (is_addr) begin
          v.push     = hit;
          v.flag     = 1'b1;
          v.addr_evt = hit;
          v.en_set   = hit & ~en;
          v.en_clr   = ~hit & en;
        end else begin
          v.push = en;
          v.flag = 1'b0;
        end
      end
      default: begin
        v.push = 1'b1;
        v.flag = perr;
      end
    endcase
    return v;
  endfunction

  md_verdict_t verdict;
  logic        hit;

  always_comb begin
    hit     = addr_hit(char_data, station);
    verdict = judge(mode, rx_en, char_bit9, hit, char_perr);
  end

  assign push_valid = char_valid & verdict.push;
  assign push_data  = char_data;
  assign push_flag  = verdict.flag;
  assign addr_evt   = char_valid & verdict.addr_evt;
  assign en_set     = char_valid & verdict.en_set;
  assign en_clr     = char_valid & verdict.en_clr;

  AST_PUSH_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    !char_valid |-> !push_valid); // R10

  AST_SOFT_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SOFT && char_valid && char_bit9) |-> (push_valid && push_flag)); // R3

  AST_AUTO_FOREIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_AUTO && char_valid && char_bit9 && char_data != station) |-> !push_valid); // R8

  AST_AUTO_IDLE_DATA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_AUTO && !rx_en && char_valid && !char_bit9) |-> !push_valid); // R7

endmodule

// File: rtl/mdrop_irq.sv
module mdrop_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic ack,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (raise) irq_q <= 1'b1;
    else if (ack)   irq_q <= 1'b0;
  end

  assign irq = irq_q;

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq); // R5

  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !raise) |=> !irq); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(raise)); // R5

endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 char_valid,
  input  logic [DATA_W-1:0]    char_data,
  input  logic                 char_bit9,
  input  logic                 char_perr,
  input  logic                 ctrl_wr,
  input  logic [CTRL_W-1:0]    ctrl_wdata,
  input  logic                 stn_wr,
  input  logic [DATA_W-1:0]    stn_wdata,
  input  logic                 irq_ack,
  output logic                 push_valid,
  output logic [DATA_W-1:0]    push_data,
  output logic                 push_flag,
  output logic                 irq,
  output logic                 rx_active
);

  md_mode_e          mode;
  logic              irq_en, rx_en;
  logic [DATA_W-1:0] station;
  logic              addr_evt, en_set, en_clr;
  logic              irq_raise;

  mdrop_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .stn_wr     (stn_wr),
    .stn_wdata  (stn_wdata),
    .auto_set   (en_set),
    .auto_clr   (en_clr),
    .mode       (mode),
    .irq_en     (irq_en),
    .rx_en      (rx_en),
    .station    (station)
  );

  mdrop_decide #(.DATA_W(DATA_W)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .rx_en      (rx_en),
    .station    (station),
    .char_valid (char_valid),
    .char_data  (char_data),
    .char_bit9  (char_bit9),
    .char_perr  (char_perr),
    .push_valid (push_valid),
    .push_data  (push_data),
    .push_flag  (push_flag),
    .addr_evt   (addr_evt),
    .en_set     (en_set),
    .en_clr     (en_clr)
  );

  assign irq_raise = addr_evt & irq_en;

  mdrop_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .raise (irq_raise),
    .ack   (irq_ack),
    .irq   (irq)
  );

  assign rx_active = rx_en;

  AST_AUTO_MATCH_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_AUTO && char_valid && char_bit9 && char_data == station && !ctrl_wr)
      |=> rx_active); // R6

  AST_AUTO_FOREIGN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_AUTO && char_valid && char_bit9 && char_data != station && !ctrl_wr)
      |=> !rx_active); // R8

  AST_OFF_NO_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_OFF) |-> !irq_raise); // R2

endmodule

// File: tb/sim_mdrop_rx_filter.sv
`timescale 1ns/1ps
module sim_mdrop_rx_filter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_valid = 1'b0;
  logic [7:0] char_data = '0;
  logic       char_bit9 = 1'b0;
  logic       char_perr = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [3:0] ctrl_wdata = '0;
  logic       stn_wr = 1'b0;
  logic [7:0] stn_wdata = '0;
  logic       irq_ack = 1'b0;
  logic       push_valid, push_flag, irq, rx_active;
  logic [7:0] push_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // control encodings: bit0 multidrop, bit1 automatic, bit2 irq enable, bit3 receiver enable
  localparam logic [3:0] C_OFF       = 4'h0;
  localparam logic [3:0] C_SOFT      = 4'h5;
  localparam logic [3:0] C_SOFT_EN   = 4'hD;
  localparam logic [3:0] C_SOFT_NOIE = 4'h1;
  localparam logic [3:0] C_AUTO      = 4'h7;
  localparam logic [3:0] C_AUTO_EN   = 4'hF;

  always #2.5 clk = ~clk;

  mdrop_rx_filter u0 (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .char_bit9(char_bit9), .char_perr(char_perr), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .stn_wr(stn_wr), .stn_wdata(stn_wdata),
    .irq_ack(irq_ack), .push_valid(push_valid), .push_data(push_data),
    .push_flag(push_flag), .irq(irq), .rx_active(rx_active)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, check push outputs mid-cycle, release after posedge.
  task automatic step(input logic v, input logic [7:0] d, input logic b9, input logic pe,
                      input logic cw, input logic [3:0] cd,
                      input logic ex_push, input logic ex_flag, input string tag);
    @(negedge clk);
    char_valid = v; char_data = d; char_bit9 = b9; char_perr = pe;
    ctrl_wr = cw; ctrl_wdata = cd;
    #1;
    chk({tag, " push"}, push_valid, ex_push);
    if (ex_push) begin
      chk({tag, " data"}, push_data, d);
      chk({tag, " flag"}, push_flag, ex_flag);
    end
    @(posedge clk); #0.5;
    char_valid = 0; ctrl_wr = 0;
  endtask

  task automatic wr_ctrl(input logic [3:0] cd);
    step(0, 8'h00, 0, 0, 1, cd, 0, 0, "R12 ctrl write");
  endtask

  task automatic wr_stn(input logic [7:0] a);
    @(negedge clk); stn_wr = 1; stn_wdata = a;
    @(posedge clk); #0.5; stn_wr = 0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(posedge clk); #0.5; irq_ack = 0;
  endtask

  task automatic t_reset_off();
    @(negedge clk);
    chk("R1 rx_active", rx_active, 0);
    chk("R1 irq", irq, 0);
    chk("R10 idle no push", push_valid, 0);
    step(1, 8'hA5, 0, 1, 0, 0, 1, 1, "R2 data perr");
    step(1, 8'h3C, 0, 0, 0, 0, 1, 0, "R2 data clean");
    step(1, 8'h5A, 1, 0, 0, 0, 1, 0, "R2 bit9 passes");
    chk("R2 no irq", irq, 0);
    // R1: station reset value 0x00 matches in automatic mode
    wr_ctrl(C_AUTO);
    step(1, 8'h00, 1, 0, 0, 0, 1, 1, "R1 station zero match");
    chk("R1 station zero enables", rx_active, 1);
    ack(); wr_ctrl(C_OFF);
    chk("R12 rx bit cleared", rx_active, 0);
  endtask

  task automatic t_soft();
    wr_ctrl(C_SOFT);
    step(1, 8'h21, 0, 0, 0, 0, 0, 0, "R3 data dropped");
    step(1, 8'h33, 1, 0, 0, 0, 1, 1, "R3 addr pushed");
    chk("R5 irq raised", irq, 1);
    chk("R4 no self enable", rx_active, 0);
    repeat (3) @(posedge clk);
    #0.5 chk("R5 irq held", irq, 1);
    ack();
    chk("R5 irq acked", irq, 0);
    wr_ctrl(C_SOFT_EN);
    chk("R12 rx enable write", rx_active, 1);
    step(1, 8'h44, 0, 1, 0, 0, 1, 0, "R4 data pushed");
    step(1, 8'h99, 1, 0, 0, 0, 1, 1, "R4 addr flagged");
    chk("R4 stays enabled", rx_active, 1);
    ack();
    wr_ctrl(C_SOFT);
    step(1, 8'h45, 0, 0, 0, 0, 0, 0, "R4 data after disable");
    wr_ctrl(C_SOFT_NOIE);
    step(1, 8'h34, 1, 0, 0, 0, 1, 1, "R5 addr irq masked");
    chk("R5 irq masked", irq, 0);
  endtask

  task automatic t_irq_race();
    wr_ctrl(C_SOFT);
    step(1, 8'h10, 1, 0, 0, 0, 1, 1, "R5 first addr");
    @(negedge clk);
    char_valid = 1; char_data = 8'h11; char_bit9 = 1; irq_ack = 1;
    @(posedge clk); #0.5;
    char_valid = 0; irq_ack = 0;
    chk("R5 raise beats ack", irq, 1);
    ack();
  endtask

  task automatic t_auto();
    wr_stn(8'h5A);
    wr_ctrl(C_AUTO);
    step(1, 8'h5A, 0, 0, 0, 0, 0, 0, "R7 data dropped");
    step(1, 8'h11, 1, 0, 0, 0, 0, 0, "R7 foreign addr dropped");
    chk("R7 still off", rx_active, 0);
    chk("R7 no irq", irq, 0);
    step(1, 8'h5A, 1, 0, 0, 0, 1, 1, "R6 match pushed");
    chk("R6 enabled", rx_active, 1);
    chk("R6 irq", irq, 1);
    ack();
    step(1, 8'h77, 0, 1, 0, 0, 1, 0, "R9 data pushed");
    step(1, 8'h5A, 1, 0, 0, 0, 1, 1, "R6 rematch pushed");
    chk("R6 stays on", rx_active, 1);
    ack();
    step(1, 8'h12, 1, 0, 0, 0, 0, 0, "R8 foreign not stored");
    chk("R8 disabled", rx_active, 0);
    chk("R8 no irq", irq, 0);
    step(1, 8'h78, 0, 0, 0, 0, 0, 0, "R7 data after close");
    step(1, 8'h5A, 1, 0, 0, 0, 1, 1, "R6 reopen");
    ack();
    wr_ctrl(C_AUTO);
    chk("R9 host disable", rx_active, 0);
    step(1, 8'h79, 0, 0, 0, 0, 0, 0, "R9 data after host off");
  endtask

  task automatic t_write_race();
    // enable written in same cycle as a data byte: the byte sees the old (off) enable
    step(1, 8'h55, 0, 0, 1, C_AUTO_EN, 0, 0, "R11 data uses old enable");
    chk("R11 write applied", rx_active, 1);
    step(1, 8'h56, 0, 0, 0, 0, 1, 0, "R11 next data pushed");
    // foreign address with host keeping enable in the same cycle: host wins
    step(1, 8'h13, 1, 0, 1, C_AUTO_EN, 0, 0, "R11 foreign with write");
    chk("R11 host beats auto close", rx_active, 1);
    // host-managed: disable written while data byte arrives, byte still pushed
    wr_ctrl(C_SOFT_EN);
    step(1, 8'h66, 0, 0, 1, C_SOFT, 1, 0, "R11 disable same cycle");
    chk("R11 disabled after", rx_active, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    t_reset_off();
    t_soft();
    t_irq_race();
    t_auto();
    t_write_race();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule